// File: doc/BRIEF.md
# Dual Circular Address Generator

This block holds two independent pointer engines for a signal-processing datapath. Each engine owns a private bank of eight pointer (index) registers, eight step (modify) registers, eight ring-size (length) registers and eight ring-start (base) registers. An access names one pointer and one step register of that engine. The engine then presents an effective address in the same cycle and, on the next clock edge, stores the advanced pointer back into the register it read. Both engines can issue an access in the same cycle, which gives a two-operand fetch.

Engine 0 only addresses data memory. Engine 1 can address either data memory or program memory. Each access picks pre-modify, post-modify or a zero step. A nonzero ring size keeps the pointer inside a circular buffer. The registers are loaded through one shared write port.

There is no back-pressure. Access requests are single-cycle strobes that the block always accepts. The address outputs are plain qualified signals and carry no ready input.

Top module: `addr_gen_pair`

## Requirements
- R1: While reset is asserted, and after it is released, every register in both banks holds zero. An access therefore yields address 0 until a register is written.
- R2: `wr_sel` 0–7 selects entry `wr_sel` of engine 0 and 8–15 selects entry `wr_sel`−8 of engine 1. `wr_type` selects the register kind: 0 pointer, 1 step, 2 ring size, 3 ring start. The write takes effect on the clock edge.
- R3: In post-modify mode (`gN_pre`=0, `gN_zero`=0), the address is the current pointer. The pointer becomes pointer+step on the next edge.
- R4: In pre-modify mode (`gN_pre`=1), the address is pointer+step after ring correction. The pointer is updated to that same value.
- R5: With `gN_zero`=1, the address is the pointer and the pointer is left unchanged.
- R6: Step values are 14-bit two's complement, so step 14'h3FFD moves the pointer down by 3.
- R7: If the ring size L is nonzero and pointer+step exceeds start+L−1, the result is reduced by L.
- R8: If L is nonzero and pointer+step is below the ring start, the result is increased by L.
- R9: If L is zero, the result is pointer+step modulo 2^14.
- R10: An engine 1 access with `g1_pm`=1 drives `pm_addr` with `pm_valid`=1 and keeps `dm_valid1`=0. With `g1_pm`=0 it drives `dm_addr1` with `dm_valid1`=1 and keeps `pm_valid`=0.
- R11: An engine 0 access with `g0_pm`=1 is ignored: `dm_valid0` stays 0 and the pointer is not updated. `g0_err` is 1 in that cycle only.
- R12: Both engines can access in the same cycle, each with its own bank, with no interaction.
- R13: A register-port write to a pointer takes priority over an access update of that pointer in the same cycle.
- R14: Addresses are combinational from the current registers. With no request, the engine's valid and address outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_type | input | 2 | Register kind: 0 pointer, 1 step, 2 ring size, 3 ring start |
| wr_sel | input | 4 | Register number 0–15 across both banks |
| wr_data | input | 14 | Write value |
| g0_req | input | 1 | Engine 0 access strobe |
| g0_idx | input | 3 | Engine 0 pointer select |
| g0_mod | input | 3 | Engine 0 step select |
| g0_zero | input | 1 | Engine 0 zero step |
| g0_pre | input | 1 | Engine 0 pre-modify mode |
| g0_pm | input | 1 | Engine 0 program-memory request (illegal) |
| g1_req | input | 1 | Engine 1 access strobe |
| g1_idx | input | 3 | Engine 1 pointer select |
| g1_mod | input | 3 | Engine 1 step select |
| g1_zero | input | 1 | Engine 1 zero step |
| g1_pre | input | 1 | Engine 1 pre-modify mode |
| g1_pm | input | 1 | Engine 1 targets program memory |
| dm_addr0 | output | 14 | Engine 0 data address |
| dm_valid0 | output | 1 | Engine 0 data address valid |
| dm_addr1 | output | 14 | Engine 1 data address |
| dm_valid1 | output | 1 | Engine 1 data address valid |
| pm_addr | output | 14 | Program memory address from engine 1 |
| pm_valid | output | 1 | Program memory address valid |
| g0_err | output | 1 | Illegal program-memory request on engine 0 |

## Verification
A corrupted pointer or a wrong ring correction does not show up at the ports until the next access to that pointer. For that reason every update is followed one cycle later by a zero-step access to the same pointer, which exposes the stored value as an address. A wrong routing or a missed rejection is visible in the same cycle as the access, on the valid flags and `g0_err`. A bank decode error shows up as a value that appears in the other engine or in the wrong entry.

// File: rtl/agp_pkg.sv
package agp_pkg;
  typedef enum logic [1:0] {
    RK_PTR   = 2'd0,
    RK_STEP  = 2'd1,
    RK_SIZE  = 2'd2,
    RK_START = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/agp_bank.sv
module agp_bank
  import agp_pkg::*;
#(
  parameter int AW = 14,
  parameter int NREG = 8,
  parameter bit BANK_ID = 1'b0,
  localparam int LW = $clog2(NREG),
  localparam int SELW = LW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  reg_kind_e       wr_kind,
  input  logic [SELW-1:0] wr_sel,
  input  logic [AW-1:0]   wr_data,
  input  logic [LW-1:0]   rd_ptr,
  input  logic [LW-1:0]   rd_step,
  input  logic            upd_en,
  input  logic [AW-1:0]   upd_val,
  output logic [AW-1:0]   ptr_o,
  output logic [AW-1:0]   step_o,
  output logic [AW-1:0]   size_o,
  output logic [AW-1:0]   start_o
);
  logic [AW-1:0] ptr_q   [NREG];
  logic [AW-1:0] step_q  [NREG];
  logic [AW-1:0] size_q  [NREG];
  logic [AW-1:0] start_q [NREG];

  logic          mine;
  logic [LW-1:0] loc;
  assign mine = wr_en && (wr_sel[SELW-1] == BANK_ID);
  assign loc  = wr_sel[LW-1:0];

  for (genvar k = 0; k < NREG; k++) begin : g_ent
    logic hit;
    assign hit = mine && (loc == LW'(k));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptr_q[k]   <= '0;
        step_q[k]  <= '0;
        size_q[k]  <= '0;
        start_q[k] <= '0;
      end else begin
        if (hit && wr_kind == RK_PTR)
          ptr_q[k] <= wr_data;
        else if (upd_en && rd_ptr == LW'(k))
          ptr_q[k] <= upd_val;
        if (hit && wr_kind == RK_STEP)  step_q[k]  <= wr_data;
        if (hit && wr_kind == RK_SIZE)  size_q[k]  <= wr_data;
        if (hit && wr_kind == RK_START) start_q[k] <= wr_data;
      end
    end
  end

  assign ptr_o   = ptr_q[rd_ptr];
  assign step_o  = step_q[rd_step];
  assign size_o  = size_q[rd_ptr];
  assign start_o = start_q[rd_ptr];
endmodule

// File: rtl/agp_step.sv
module agp_step #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] size,
  input  logic [AW-1:0] start,
  input  logic          zero,
  input  logic          pre,
  output logic [AW-1:0] eff,
  output logic [AW-1:0] nxt
);
  localparam int XW = AW + 2;
  localparam logic signed [XW-1:0] ONE = XW'(1);

  logic signed [XW-1:0] sum, top, lo, ring, fixd;
  logic [AW-1:0] inc;

  always_comb begin
    inc  = zero ? '0 : step;
    sum  = $signed({2'b00, ptr}) + $signed({{2{inc[AW-1]}}, inc});
    lo   = $signed({2'b00, start});
    ring = $signed({2'b00, size});
    top  = lo + ring - ONE;
    fixd = sum;
    if (size != '0) begin
      if (sum > top)     fixd = sum - ring;
      else if (sum < lo) fixd = sum + ring;
    end
    nxt = fixd[AW-1:0];
    eff = pre ? nxt : ptr;
  end
endmodule

// File: rtl/addr_gen_pair.sv
module addr_gen_pair
  import agp_pkg::*;
#(
  parameter int AW = 14,
  parameter int NREG = 8,
  localparam int LW = $clog2(NREG),
  localparam int SELW = LW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_type,
  input  logic [SELW-1:0] wr_sel,
  input  logic [AW-1:0]   wr_data,
  input  logic            g0_req,
  input  logic [LW-1:0]   g0_idx,
  input  logic [LW-1:0]   g0_mod,
  input  logic            g0_zero,
  input  logic            g0_pre,
  input  logic            g0_pm,
  input  logic            g1_req,
  input  logic [LW-1:0]   g1_idx,
  input  logic [LW-1:0]   g1_mod,
  input  logic            g1_zero,
  input  logic            g1_pre,
  input  logic            g1_pm,
  output logic [AW-1:0]   dm_addr0,
  output logic            dm_valid0,
  output logic [AW-1:0]   dm_addr1,
  output logic            dm_valid1,
  output logic [AW-1:0]   pm_addr,
  output logic            pm_valid,
  output logic            g0_err
);
  localparam int NG = 2;

  logic [NG-1:0] req_v, zero_v, pre_v, pm_v, ok_v;
  logic [LW-1:0] idx_v [NG];
  logic [LW-1:0] mod_v [NG];
  logic [AW-1:0] eff_v [NG];
  reg_kind_e     kind;

  assign kind   = reg_kind_e'(wr_type);
  assign req_v  = {g1_req, g0_req};
  assign zero_v = {g1_zero, g0_zero};
  assign pre_v  = {g1_pre, g0_pre};
  assign pm_v   = {g1_pm, g0_pm};
  assign idx_v[0] = g0_idx;
  assign idx_v[1] = g1_idx;
  assign mod_v[0] = g0_mod;
  assign mod_v[1] = g1_mod;

  for (genvar g = 0; g < NG; g++) begin : g_eng
    logic [AW-1:0] p, s, l, b, nx;
    // engine 0 cannot reach program memory: such a request is dropped
    if (g == 0) begin : g_dm_only
      assign ok_v[g] = req_v[g] && !pm_v[g];
    end else begin : g_dual
      assign ok_v[g] = req_v[g];
    end

    agp_bank #(.AW(AW), .NREG(NREG), .BANK_ID(g[0])) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_kind (kind),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .rd_ptr  (idx_v[g]),
      .rd_step (mod_v[g]),
      .upd_en  (ok_v[g] && !zero_v[g]),
      .upd_val (nx),
      .ptr_o   (p),
      .step_o  (s),
      .size_o  (l),
      .start_o (b)
    );

    agp_step #(.AW(AW)) u_step (
      .ptr   (p),
      .step  (s),
      .size  (l),
      .start (b),
      .zero  (zero_v[g]),
      .pre   (pre_v[g]),
      .eff   (eff_v[g]),
      .nxt   (nx)
    );
  end

  assign dm_valid0 = ok_v[0];
  assign dm_addr0  = ok_v[0] ? eff_v[0] : '0;
  assign g0_err    = g0_req && g0_pm;
  assign dm_valid1 = ok_v[1] && !g1_pm;
  assign dm_addr1  = dm_valid1 ? eff_v[1] : '0;
  assign pm_valid  = ok_v[1] && g1_pm;
  assign pm_addr   = pm_valid ? eff_v[1] : '0;
endmodule

// File: rtl/agp_checker.sv
module agp_checker #(
  parameter int AW = 14,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          g0_req,
  input logic [LW-1:0] g0_idx,
  input logic          g0_zero,
  input logic          g0_pm,
  input logic          g1_req,
  input logic          g1_pm,
  input logic [AW-1:0] dm_addr0,
  input logic          dm_valid0,
  input logic          dm_valid1,
  input logic          pm_valid,
  input logic          g0_err
);
  // R11
  g0_pm_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g0_req && g0_pm) |-> (g0_err && !dm_valid0));

  // R10
  g1_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g1_req && g1_pm) |-> (pm_valid && !dm_valid1));

  // R10
  g1_single_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_valid && dm_valid1));

  // R14
  g0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !g0_req |-> (!dm_valid0 && dm_addr0 == '0 && !g0_err));

  // R5
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g0_req && !g0_pm && g0_zero && $past(g0_req && !g0_pm && g0_zero && !wr_en)
     && g0_idx == $past(g0_idx)) |-> dm_addr0 == $past(dm_addr0));
endmodule

bind addr_gen_pair agp_checker #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .g0_req(g0_req), .g0_idx(g0_idx),
  .g0_zero(g0_zero), .g0_pm(g0_pm), .g1_req(g1_req), .g1_pm(g1_pm),
  .dm_addr0(dm_addr0), .dm_valid0(dm_valid0), .dm_valid1(dm_valid1),
  .pm_valid(pm_valid), .g0_err(g0_err)
);

// File: tb/addr_gen_pair_bench.sv
module addr_gen_pair_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_type = 0;
  logic [3:0] wr_sel = 0;
  logic [13:0] wr_data = 0;
  logic g0_req = 0, g0_zero = 0, g0_pre = 0, g0_pm = 0;
  logic [2:0] g0_idx = 0, g0_mod = 0;
  logic g1_req = 0, g1_zero = 0, g1_pre = 0, g1_pm = 0;
  logic [2:0] g1_idx = 0, g1_mod = 0;
  logic [13:0] dm_addr0, dm_addr1, pm_addr;
  logic dm_valid0, dm_valid1, pm_valid, g0_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  addr_gen_pair u_addr_gen_pair (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic idle();
    g0_req = 0; g1_req = 0; g0_pm = 0; g1_pm = 0; wr_en = 0;
  endtask

  task automatic wreg(input logic [1:0] t, input logic [3:0] s, input logic [13:0] d);
    wr_en = 1; wr_type = t; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic go0(input logic [2:0] i, input logic [2:0] m, input logic z, input logic p, input logic pm);
    g0_req = 1; g0_idx = i; g0_mod = m; g0_zero = z; g0_pre = p; g0_pm = pm;
  endtask

  task automatic go1(input logic [2:0] i, input logic [2:0] m, input logic z, input logic p, input logic pm);
    g1_req = 1; g1_idx = i; g1_mod = m; g1_zero = z; g1_pre = p; g1_pm = pm;
  endtask

  task automatic peek0(input logic [2:0] i, output logic [13:0] a);
    go0(i, 0, 1, 0, 0); #1 a = dm_addr0;
    @(negedge clk); idle();
  endtask

  task automatic peek1(input logic [2:0] i, output logic [13:0] a);
    go1(i, 0, 1, 0, 0); #1 a = dm_addr1;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    logic [13:0] a;
    go0(3, 0, 1, 0, 0); #1 chk("R1 addr in reset", dm_addr0, 0);
    @(negedge clk); idle(); rst_n = 1;
    peek1(5, a); chk("R1 engine1 ptr zero", a, 0);
    go0(2, 2, 0, 1, 0); #1 chk("R1 step zero pre", dm_addr0, 0);
    @(negedge clk); idle();
  endtask

  task automatic t_write();
    logic [13:0] a;
    wreg(0, 3, 100); wreg(0, 11, 200);
    peek0(3, a); chk("R2 bank0 entry3", a, 100);
    peek1(3, a); chk("R2 bank1 entry3", a, 200);
  endtask

  task automatic t_post();
    logic [13:0] a;
    wreg(0, 0, 10); wreg(1, 0, 1);
    go0(0, 0, 0, 0, 0); #1 chk("R3 post addr", dm_addr0, 10);
    chk("R14 valid", dm_valid0, 1);
    @(negedge clk); idle();
    peek0(0, a); chk("R3 post update", a, 11);
  endtask

  task automatic t_pre();
    logic [13:0] a;
    wreg(0, 1, 20); wreg(1, 1, 5);
    go0(1, 1, 0, 1, 0); #1 chk("R4 pre addr", dm_addr0, 25);
    @(negedge clk); idle();
    peek0(1, a); chk("R4 pre update", a, 25);
  endtask

  task automatic t_zero();
    logic [13:0] a;
    wreg(0, 2, 7); wreg(1, 2, 3);
    go0(2, 2, 1, 0, 0); #1 chk("R5 zero addr", dm_addr0, 7);
    @(negedge clk); idle();
    peek0(2, a); chk("R5 zero unchanged", a, 7);
  endtask

  task automatic t_neg();
    logic [13:0] a;
    wreg(0, 4, 50); wreg(1, 4, 14'h3FFD);
    go0(4, 4, 0, 0, 0); @(negedge clk); idle();
    peek0(4, a); chk("R6 negative step", a, 47);
  endtask

  task automatic t_wrap_hi();
    logic [13:0] a;
    wreg(3, 8, 100); wreg(2, 8, 10); wreg(0, 8, 108); wreg(1, 8, 5);
    go1(0, 0, 0, 0, 0); #1 chk("R7 addr before wrap", dm_addr1, 108);
    @(negedge clk); idle();
    peek1(0, a); chk("R7 wrap above", a, 103);
    go1(0, 0, 0, 1, 0); #1 chk("R7 pre in ring", dm_addr1, 108);
    @(negedge clk); idle();
  endtask

  task automatic t_wrap_lo();
    logic [13:0] a;
    wreg(3, 9, 100); wreg(2, 9, 10); wreg(0, 9, 101); wreg(1, 9, 14'h3FFC);
    go1(1, 1, 0, 1, 0); #1 chk("R8 pre wrap below addr", dm_addr1, 107);
    @(negedge clk); idle();
    peek1(1, a); chk("R8 wrap below", a, 107);
  endtask

  task automatic t_nowrap();
    logic [13:0] a;
    wreg(0, 5, 16380); wreg(1, 5, 10);
    go0(5, 5, 0, 0, 0); @(negedge clk); idle();
    peek0(5, a); chk("R9 modulo up", a, 6);
    wreg(0, 6, 2); wreg(1, 6, 14'h3FFB);
    go0(6, 6, 0, 0, 0); @(negedge clk); idle();
    peek0(6, a); chk("R9 modulo down", a, 16381);
  endtask

  task automatic t_pm();
    wreg(0, 12, 1234);
    go1(4, 0, 1, 0, 1); #1
    chk("R10 pm addr", pm_addr, 1234);
    chk("R10 pm valid", pm_valid, 1);
    chk("R10 dm idle", dm_valid1, 0);
    @(negedge clk); idle();
    go1(4, 0, 1, 0, 0); #1
    chk("R10 dm path", dm_addr1, 1234);
    chk("R10 pm idle", pm_valid, 0);
    @(negedge clk); idle();
  endtask

  task automatic t_err();
    logic [13:0] a;
    wreg(0, 7, 300); wreg(1, 7, 4);
    go0(7, 7, 0, 0, 1); #1
    chk("R11 err flag", g0_err, 1);
    chk("R11 no dm", dm_valid0, 0);
    chk("R11 no pm", pm_valid, 0);
    @(negedge clk); idle(); #1
    chk("R11 err clears", g0_err, 0);
    peek0(7, a); chk("R11 ptr unchanged", a, 300);
  endtask

  task automatic t_dual();
    logic [13:0] a;
    wreg(0, 0, 500); wreg(1, 0, 2); wreg(0, 10, 40); wreg(1, 10, 7);
    go0(0, 0, 0, 0, 0); go1(2, 2, 0, 1, 0); #1
    chk("R12 engine0 addr", dm_addr0, 500);
    chk("R12 engine1 addr", dm_addr1, 47);
    @(negedge clk); idle();
    peek0(0, a); chk("R12 engine0 update", a, 502);
    peek1(2, a); chk("R12 engine1 update", a, 47);
  endtask

  task automatic t_prio();
    logic [13:0] a;
    go0(0, 0, 0, 0, 0);
    wr_en = 1; wr_type = 0; wr_sel = 0; wr_data = 900;
    @(negedge clk); idle();
    peek0(0, a); chk("R13 write wins", a, 900);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset(); t_write(); t_post(); t_pre(); t_zero(); t_neg();
    t_wrap_hi(); t_wrap_lo(); t_nowrap(); t_pm(); t_err(); t_dual(); t_prio();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule